// File: doc/BRIEF.md
# Serial NAND Programmed-I/O Shift Engine

This block is a register-mapped shift engine for serial NAND flash. Software writes small command words into it, and each accepted write moves one segment of one to four bytes to or from the flash. A segment uses one, two or four data lines. The engine generates the serial clock (mode 0, with a programmable divider), shifts the bits at the chosen line width and drives one active-low select line per device. Software holds a select line low across several segments.

An operation on the flash is built in software as a series of segments. The opcode and a single-line address go out together: the opcode sits in the top byte and a k-byte address is left-aligned directly beneath it. A wide address is sent as a segment of its own. A dummy phase is a transmit segment of zero bytes at the required width and count. Read data comes back one word of up to four bytes at a time. Software polls the status word between segments.

Top module: `snand_pio_engine`

## Requirements
- R1: After reset every select output is high, `sck` is low, `io_oe` is zero and the status word (offset 5) reads zero.
- R2: A write to offset 0 sets `cs_n[n]` to bit 4*n of the written word from the next cycle. Writing all ones deselects every device. This register accepts writes even while a segment runs.
- R3: A write to offset 1 arms a transmit segment but shifts nothing. Bits 1:0 hold the byte count minus one. Bits 29:28 select the width: 0 is one line, 1 is two lines, 2 and 3 are four lines. The register reads back in the same layout.
- R4: When idle, a write to offset 3 sends the armed number of bytes from the written word, starting at bits 31:24 and moving to lower bytes. One-line mode uses `io_out[0]`. Two-line mode uses `io_out[1:0]`, with bit 1 carrying the more significant bit. Four-line mode uses `io_out[3:0]`, with bit 3 the most significant. `io_oe` enables only the lines in use.
- R5: When idle, a write to offset 2 (same length and width layout as offset 1) starts a receive segment. Bits are sampled from `io_in[1]` in one-line mode, from `io_in[1:0]` in two-line mode and from `io_in[3:0]` in four-line mode. The received bytes are packed most significant first into the word at offset 4, and unused low bytes read as zero.
- R6: `sck` idles low. Outputs change only when `sck` falls and stay stable while it is high, and inputs are sampled when it rises.
- R7: Offset 6 holds the divider D in bits 7:0. Each half period of `sck` lasts D+1 clock cycles. A segment therefore keeps the busy flag set for 2*(D+1)*8*bytes/lines cycles.
- R8: In the status word, bit 3 is the busy flag, bit 2 marks a receive in progress and bit 1 marks a transmit in progress. The flags are set from the cycle after the launching write until the segment ends.
- R9: While busy, writes to offsets 1, 2, 3 and 6 have no effect. This includes a write in the last busy cycle.
- R10: While idle, `io_oe` is zero. During a receive, one-line mode drives only `io[0]` (low), and the wider modes drive no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sck | output | 1 | Serial clock to the flash |
| cs_n | output | NUM_CS | Active-low device selects |
| io_out | output | 4 | Data driven on the data lines |
| io_oe | output | 4 | Output enable per data line |
| io_in | input | 4 | Data sampled from the data lines |

## Verification
Two functions can meet in one cycle: a command write can land in the final busy cycle of a segment, on the same clock edge that ends the shift. The bench provokes this by launching a segment with a known length, counting exactly the busy cycles that R7 predicts and issuing a data-register write in the last one. It judges the result from the ports: the status must read idle on the next cycle and stay idle, and the serial clock must stay low, so the late write did not launch a new segment. The select register is written during a transfer without disturbing the transfer, and a scoreboard compares every shifted word against the data the driver queued.

// File: rtl/snand_pkg.sv
package snand_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned MAX_LANES = 4;
    localparam int unsigned ADDR_W    = 3;
    localparam int unsigned STEP_W    = 6;
    localparam int unsigned WSEL_LSB  = 28;
    localparam int unsigned CS_STRIDE = 4;

    localparam logic [ADDR_W-1:0] OFS_CSEL   = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_TXCMD  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_RXCMD  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_TXDAT  = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_RXDAT  = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_CLKDIV = 3'd6;

    typedef enum logic [1:0] {
        WID_X1  = 2'd0,
        WID_X2  = 2'd1,
        WID_X4  = 2'd2,
        WID_X4B = 2'd3
    } wid_e;

    typedef struct packed {
        logic [1:0] len_m1;
        wid_e       wid;
    } seg_cfg_t;

    // number of shift steps (sck periods) in one segment
    function automatic logic [STEP_W-1:0] seg_steps(input seg_cfg_t c);
        logic [STEP_W-1:0] nbytes;
        nbytes = {{(STEP_W-2){1'b0}}, c.len_m1} + 1'b1;
        case (c.wid)
            WID_X1:  return nbytes << 3;
            WID_X2:  return nbytes << 2;
            default: return nbytes << 1;
        endcase
    endfunction
endpackage

// File: rtl/snand_clkdiv.sv
module snand_clkdiv #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.cnt == div);
        if (!run || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/snand_shifter.sv
module snand_shifter
    import snand_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 start_rx,
    input  seg_cfg_t             cfg,
    input  logic [WORD_W-1:0]    tx_word,
    input  logic                 tick,
    input  logic [MAX_LANES-1:0] io_in,
    output logic                 busy,
    output logic                 rx_busy,
    output logic                 sck,
    output logic                 rx_done,
    output logic [WORD_W-1:0]    rx_word,
    output logic [MAX_LANES-1:0] io_out,
    output logic [MAX_LANES-1:0] io_oe
);
    typedef struct packed {
        logic              busy;
        logic              rx;
        logic              sck;
        seg_cfg_t          cfg;
        logic [STEP_W-1:0] steps;
        logic [WORD_W-1:0] tx_sh;
        logic [WORD_W-1:0] rx_sh;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        rx_done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.rx    = start_rx;
                st_d.sck   = 1'b0;
                st_d.cfg   = cfg;
                st_d.steps = seg_steps(cfg);
                st_d.tx_sh = start_rx ? '0 : tx_word;
                st_d.rx_sh = '0;
            end
        end else if (tick) begin
            if (!st_q.sck) begin
                // rising edge: sample the lines
                st_d.sck = 1'b1;
                case (st_q.cfg.wid)
                    WID_X1:  st_d.rx_sh = {st_q.rx_sh[WORD_W-2:0], io_in[1]};
                    WID_X2:  st_d.rx_sh = {st_q.rx_sh[WORD_W-3:0], io_in[1:0]};
                    default: st_d.rx_sh = {st_q.rx_sh[WORD_W-MAX_LANES-1:0], io_in};
                endcase
            end else begin
                // falling edge: present the next bits
                st_d.sck = 1'b0;
                case (st_q.cfg.wid)
                    WID_X1:  st_d.tx_sh = st_q.tx_sh << 1;
                    WID_X2:  st_d.tx_sh = st_q.tx_sh << 2;
                    default: st_d.tx_sh = st_q.tx_sh << MAX_LANES;
                endcase
                st_d.steps = st_q.steps - 1'b1;
                if (st_q.steps == {{(STEP_W-1){1'b0}}, 1'b1}) begin
                    st_d.busy = 1'b0;
                    st_d.rx   = 1'b0;
                    rx_done   = st_q.rx;
                end
            end
        end
    end

    always_comb begin
        io_out = '0;
        io_oe  = '0;
        if (st_q.busy) begin
            case (st_q.cfg.wid)
                WID_X1: begin
                    io_out = {{(MAX_LANES-1){1'b0}}, st_q.tx_sh[WORD_W-1]};
                    io_oe  = {{(MAX_LANES-1){1'b0}}, 1'b1};
                end
                WID_X2: begin
                    io_out = {{(MAX_LANES-2){1'b0}}, st_q.tx_sh[WORD_W-1 -: 2]};
                    io_oe  = st_q.rx ? '0 : {{(MAX_LANES-2){1'b0}}, 2'b11};
                end
                default: begin
                    io_out = st_q.tx_sh[WORD_W-1 -: MAX_LANES];
                    io_oe  = st_q.rx ? '0 : '1;
                end
            endcase
        end
    end

    assign busy    = st_q.busy;
    assign rx_busy = st_q.rx;
    assign sck     = st_q.sck;
    assign rx_word = st_q.rx_sh << {(2'd3 - st_q.cfg.len_m1), 3'b000};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/snand_pio_engine.sv
module snand_pio_engine
    import snand_pkg::*;
#(
    parameter int unsigned NUM_CS = 2,
    parameter int unsigned DIV_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic                 sck,
    output logic [NUM_CS-1:0]    cs_n,
    output logic [MAX_LANES-1:0] io_out,
    output logic [MAX_LANES-1:0] io_oe,
    input  logic [MAX_LANES-1:0] io_in
);
    localparam int unsigned CFG_GAP = WSEL_LSB - 2;

    typedef struct packed {
        logic [NUM_CS-1:0] cs_n;
        seg_cfg_t          tx_cfg;
        seg_cfg_t          rx_cfg;
        logic [DIV_W-1:0]  div;
        logic [WORD_W-1:0] rxdat;
    } top_st_t;

    top_st_t top_d, top_q;

    logic              eng_busy, eng_rx, tick, rx_done;
    logic              accept, launch_tx, launch_rx;
    seg_cfg_t          wr_cfg, seg_cfg;
    logic [WORD_W-1:0] rx_word, csel_rb;
    logic [1:0]        tx_len_w, rx_len_w;
    logic [3:0]        tx_cfg_w;
    logic [DIV_W-1:0]  div_w;
    logic [WORD_W-1:0] rxdat_w;
    logic              unused_wdata;

    function automatic logic [WORD_W-1:0] cfg_word(input seg_cfg_t c);
        return {{(WORD_W-WSEL_LSB-2){1'b0}}, c.wid, {CFG_GAP{1'b0}}, c.len_m1};
    endfunction

    always_comb begin
        wr_cfg.len_m1 = bus_wdata[1:0];
        wr_cfg.wid    = wid_e'(bus_wdata[WSEL_LSB+1:WSEL_LSB]);
        accept        = bus_we && !eng_busy;
        launch_tx     = accept && (bus_addr == OFS_TXDAT);
        launch_rx     = accept && (bus_addr == OFS_RXCMD);
        seg_cfg       = launch_rx ? wr_cfg : top_q.tx_cfg;

        top_d = top_q;
        if (bus_we && (bus_addr == OFS_CSEL)) begin
            for (int n = 0; n < NUM_CS; n++) begin
                top_d.cs_n[n] = bus_wdata[CS_STRIDE*n];
            end
        end
        if (accept && (bus_addr == OFS_TXCMD)) begin
            top_d.tx_cfg = wr_cfg;
        end
        if (launch_rx) begin
            top_d.rx_cfg = wr_cfg;
        end
        if (accept && (bus_addr == OFS_CLKDIV)) begin
            top_d.div = bus_wdata[DIV_W-1:0];
        end
        if (rx_done) begin
            top_d.rxdat = rx_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q      <= '0;
            top_q.cs_n <= '1;
        end else begin
            top_q <= top_d;
        end
    end

    // select register read-back: unused bits read as one
    for (genvar b = 0; b < WORD_W; b++) begin : g_csel_rb
        if ((b % CS_STRIDE == 0) && (b / CS_STRIDE < NUM_CS)) begin : g_sel
            assign csel_rb[b] = top_q.cs_n[b/CS_STRIDE];
        end else begin : g_pad
            assign csel_rb[b] = 1'b1;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_CSEL:   bus_rdata = csel_rb;
            OFS_TXCMD:  bus_rdata = cfg_word(top_q.tx_cfg);
            OFS_RXCMD:  bus_rdata = cfg_word(top_q.rx_cfg);
            OFS_RXDAT:  bus_rdata = rxdat_w;
            OFS_STAT:   bus_rdata = {{(WORD_W-4){1'b0}}, eng_busy, eng_rx, eng_busy & ~eng_rx, 1'b0};
            OFS_CLKDIV: bus_rdata = {{(WORD_W-DIV_W){1'b0}}, div_w};
            default:    bus_rdata = '0;
        endcase
    end

    snand_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (eng_busy),
        .div   (div_w),
        .tick  (tick)
    );

    snand_shifter u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (launch_tx || launch_rx),
        .start_rx (launch_rx),
        .cfg      (seg_cfg),
        .tx_word  (bus_wdata),
        .tick     (tick),
        .io_in    (io_in),
        .busy     (eng_busy),
        .rx_busy  (eng_rx),
        .sck      (sck),
        .rx_done  (rx_done),
        .rx_word  (rx_word),
        .io_out   (io_out),
        .io_oe    (io_oe)
    );

    assign cs_n         = top_q.cs_n;
    assign tx_len_w     = top_q.tx_cfg.len_m1;
    assign tx_cfg_w     = top_q.tx_cfg;
    assign rx_len_w     = top_q.rx_cfg.len_m1;
    assign div_w        = top_q.div;
    assign rxdat_w      = top_q.rxdat;
    assign unused_wdata = ^{bus_wdata, tx_len_w, rx_len_w, tx_cfg_w};
endmodule

// File: rtl/snand_pio_checks.sv
module snand_pio_checks
    import snand_pkg::*;
#(
    parameter int unsigned NUM_CS = 2,
    parameter int unsigned DIV_W  = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_we,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [WORD_W-1:0]    bus_wdata,
    input logic                 sck,
    input logic [NUM_CS-1:0]    cs_n,
    input logic [MAX_LANES-1:0] io_out,
    input logic [MAX_LANES-1:0] io_oe,
    input logic                 busy,
    input logic                 rx_busy,
    input logic [3:0]           tx_cfg,
    input logic [1:0]           rx_len,
    input logic [DIV_W-1:0]     div,
    input logic [WORD_W-1:0]    rxdat
);
    AST_CS_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_CSEL && (&bus_wdata)) |=> (&cs_n)) else $error("cs"); // R2

    AST_RX_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rx_busy) && rx_len == 2'd0) |-> (rxdat[WORD_W-9:0] == '0)) else $error("pad"); // R5

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck) else $error("sck idle"); // R6

    AST_IO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sck |=> (!sck || $stable(io_out))) else $error("io hold"); // R6

    AST_TXCMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_we && bus_addr == OFS_TXCMD) |=> $stable(tx_cfg)) else $error("txcmd"); // R9

    AST_DIV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_we && bus_addr == OFS_CLKDIV) |=> $stable(div)) else $error("div"); // R9

    AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (io_oe == '0)) else $error("oe idle"); // R10
endmodule

bind snand_pio_engine snand_pio_checks #(.NUM_CS(NUM_CS), .DIV_W(DIV_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sck       (sck),
    .cs_n      (cs_n),
    .io_out    (io_out),
    .io_oe     (io_oe),
    .busy      (eng_busy),
    .rx_busy   (eng_rx),
    .tx_cfg    (tx_cfg_w),
    .rx_len    (rx_len_w),
    .div       (div_w),
    .rxdat     (rxdat_w)
);

// File: tb/snand_pio_engine_tb.sv
module snand_pio_engine_tb;
    localparam logic [2:0] A_CSEL = 3'd0, A_TXCMD = 3'd1, A_RXCMD = 3'd2, A_TXDAT = 3'd3,
                           A_RXDAT = 3'd4, A_STAT = 3'd5, A_CLKDIV = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = A_STAT;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sck;
    logic [1:0]  cs_n;
    logic [3:0]  io_out, io_oe, io_in;

    int n_cmp = 0;
    int n_bad = 0;
    int cur_div = 0;
    bit rx_mode = 1'b0;
    logic [31:0] sl_pat = '0;
    int sl_w = 1;

    typedef struct {
        int          lanes;
        int          nbits;
        logic [31:0] exp;
    } item_t;
    item_t exp_q[$];
    logic [31:0] cap = '0;
    int cap_n = 0;

    always #5 clk = ~clk;

    snand_pio_engine u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .cs_n(cs_n),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    // flash-side model: drives the top bits of the pattern
    always_comb begin
        if (sl_w == 1)      io_in = {2'b00, sl_pat[31], 1'b0};
        else if (sl_w == 2) io_in = {2'b00, sl_pat[31:30]};
        else                io_in = sl_pat[31:28];
    end

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: collects transmitted bits on each rising sck
    always @(posedge sck) begin
        if (exp_q.size() == 0) begin
            if (!rx_mode) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R9 unexpected sck edge: actual 1 expected 0");
            end
        end else begin
            if (exp_q[0].lanes == 1)      cap = {cap[30:0], io_out[0]};
            else if (exp_q[0].lanes == 2) cap = {cap[29:0], io_out[1:0]};
            else                          cap = {cap[27:0], io_out};
            cap_n += exp_q[0].lanes;
            if (cap_n >= exp_q[0].nbits) begin
                chk("R4 shifted word", cap, exp_q[0].exp);
                void'(exp_q.pop_front());
                cap   = '0;
                cap_n = 0;
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_addr  = A_STAT;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
        bus_addr = A_STAT;
    endtask

    function automatic logic [31:0] cmd(input int len_m1, input int wid);
        return (32'(wid) << 28) | 32'(len_m1);
    endfunction

    function automatic int lanes_of(input int wid);
        return (wid == 0) ? 1 : (wid == 1) ? 2 : 4;
    endfunction

    task automatic wait_idle(output int cyc);
        logic [31:0] s;
        cyc = 0;
        rd(A_STAT, s);
        while (s[3]) begin
            cyc++;
            @(negedge clk);
            rd(A_STAT, s);
        end
    endtask

    task automatic tx_seg(input int len_m1, input int wid, input logic [31:0] d, input string tag);
        int ln, nb, cyc;
        logic [31:0] s;
        ln = lanes_of(wid);
        nb = (len_m1 + 1) * 8;
        exp_q.push_back('{ln, nb, d >> (32 - nb)});
        wr(A_TXCMD, cmd(len_m1, wid));
        wr(A_TXDAT, d);
        rd(A_STAT, s);
        chk({tag, " R8 status during transmit"}, s, 32'h0000_000A);
        chk({tag, " R4 output enables"}, {28'd0, io_oe}, 32'((1 << ln) - 1));
        wait_idle(cyc);
        chk({tag, " R7 busy cycles"}, 32'(cyc), 32'(2 * (cur_div + 1) * nb / ln));
        chk({tag, " R4 scoreboard drained"}, 32'(exp_q.size()), 32'd0);
    endtask

    task automatic rx_seg(input int len_m1, input int wid, input logic [31:0] pat,
                          input logic [31:0] exp, input logic [3:0] oe_exp, input string tag);
        int ln, cyc;
        logic [31:0] s;
        ln = lanes_of(wid);
        rx_mode = 1'b1;
        sl_w    = ln;
        sl_pat  = pat;
        wr(A_RXCMD, cmd(len_m1, wid));
        rd(A_STAT, s);
        chk({tag, " R8 status during receive"}, s, 32'h0000_000C);
        chk({tag, " R10 receive output enables"}, {28'd0, io_oe}, {28'd0, oe_exp});
        repeat ((len_m1 + 1) * 8 / ln) begin
            @(negedge sck);
            sl_pat = sl_pat << ln;
        end
        @(negedge clk);
        wait_idle(cyc);
        rd(A_RXDAT, s);
        chk({tag, " R5 received word"}, s, exp);
        rx_mode = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] v;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 cs_n after reset", {30'd0, cs_n}, 32'd3);
        chk("R1 sck after reset", {31'd0, sck}, 32'd0);
        chk("R1 io_oe after reset", {28'd0, io_oe}, 32'd0);
        rd(A_STAT, v);
        chk("R1 status after reset", v, 32'd0);

        // R2 select register
        wr(A_CSEL, 32'hFFFF_FFFE);
        chk("R2 select device 0", {30'd0, cs_n}, 32'd2);
        wr(A_CSEL, 32'hFFFF_FFEF);
        chk("R2 select device 1", {30'd0, cs_n}, 32'd1);
        wr(A_CSEL, 32'hFFFF_FFFF);
        chk("R2 deselect all", {30'd0, cs_n}, 32'd3);
        wr(A_CSEL, 32'hFFFF_FFFE);

        // R3 arming alone shifts nothing
        wr(A_TXCMD, cmd(3, 2));
        repeat (8) @(negedge clk);
        rd(A_STAT, v);
        chk("R3 arm only, status idle", v, 32'd0);
        chk("R3 arm only, sck low", {31'd0, sck}, 32'd0);
        rd(A_TXCMD, v);
        chk("R3 command read-back", v, 32'h2000_0003);

        cur_div = 1;
        wr(A_CLKDIV, 32'd1);
        tx_seg(0, 0, 32'hA5_00_00_00, "single 1B");
        tx_seg(2, 1, 32'h0F_12_34_00, "dual opcode+addr");
        tx_seg(3, 2, 32'hDEAD_BEEF, "quad 4B");
        tx_seg(1, 2, 32'h0000_0000, "dummy quad 2B");
        cur_div = 3;
        wr(A_CLKDIV, 32'd3);
        tx_seg(1, 0, 32'hC35A_0000, "single 2B div3");

        // select change while a segment runs (R2)
        exp_q.push_back('{1, 8, 32'h66});
        wr(A_TXCMD, cmd(0, 0));
        wr(A_TXDAT, 32'h6600_0000);
        wr(A_CSEL, 32'hFFFF_FFEF);
        chk("R2 select during transfer", {30'd0, cs_n}, 32'd1);
        wait_idle(cyc);
        wr(A_CSEL, 32'hFFFF_FFFE);

        rx_seg(1, 0, 32'h9ABC_FFFF, 32'h9ABC_0000, 4'b0001, "rx single 2B");
        rx_seg(0, 1, 32'h7EFF_FFFF, 32'h7E00_0000, 4'b0000, "rx dual 1B");
        rx_seg(3, 2, 32'h1357_9BDF, 32'h1357_9BDF, 4'b0000, "rx quad 4B");

        // R9 writes while busy are ignored
        cur_div = 0;
        wr(A_CLKDIV, 32'd0);
        exp_q.push_back('{1, 8, 32'h3C});
        wr(A_TXCMD, cmd(0, 0));
        wr(A_TXDAT, 32'h3C00_0000);
        wr(A_TXDAT, 32'hFF00_0000);
        wr(A_TXCMD, cmd(3, 2));
        wr(A_CLKDIV, 32'd5);
        wr(A_RXCMD, cmd(3, 2));
        wait_idle(cyc);
        repeat (4) @(negedge clk);
        rd(A_TXCMD, v);
        chk("R9 command unchanged", v, 32'd0);
        rd(A_CLKDIV, v);
        chk("R9 divider unchanged", v, 32'd0);
        rd(A_RXDAT, v);
        chk("R9 receive word unchanged", v, 32'h1357_9BDF);
        chk("R9 scoreboard drained", 32'(exp_q.size()), 32'd0);

        // R9 boundary: write in the last busy cycle (16 cycles at divider 0)
        exp_q.push_back('{1, 8, 32'h81});
        wr(A_TXDAT, 32'h8100_0000);
        repeat (15) @(negedge clk);
        rd(A_STAT, v);
        chk("R8 busy in last cycle", v, 32'h0000_000A);
        wr(A_TXDAT, 32'h5500_0000);
        rd(A_STAT, v);
        chk("R9 late write not launched", v, 32'd0);
        repeat (10) @(negedge clk);
        rd(A_STAT, v);
        chk("R9 still idle", v, 32'd0);
        chk("R6 sck low when idle", {31'd0, sck}, 32'd0);
        chk("R10 io_oe zero when idle", {28'd0, io_oe}, 32'd0);

        report();
    end
endmodule